// File: doc/BRIEF.md
# Translation buffer pointer and tag target unit

This block sits beside a memory management unit and keeps two 64-bit software-visible registers. The first is the buffer descriptor register. It holds the base address of the in-memory translation storage buffer, a split flag and a size code. The second is the fault tag register. It holds the faulting virtual address together with its 13-bit context number. From these two registers the block derives three read-only values. Two are pointers to the buffer entry that a miss handler should probe: one for an 8 KB page and one for a 64 KB page. The third is a tag-target word, which is the fault tag rearranged so that it can be compared directly against a buffer entry's tag.

Software reaches the block through one write port and one read port, both addressed by a 4-bit register index. A write lands on the next rising clock edge. Reads are combinational from the stored registers, so a value written at one edge is visible on the read port in the cycle after that edge. The derived values have no storage of their own. They are recomputed from the two registers whenever either one changes.

Top module: `tsb_ptr_unit`

## Requirements
- R1: After a synchronous active-low reset, both stored registers are zero and every read index returns zero.
- R2: A write with index 5 loads the descriptor register and a write with index 6 loads the fault tag register, all 64 bits, at the clock edge of the write. Reading index 5 or 6 returns the stored value from the next cycle on.
- R3: Writes to any index other than 5 or 6 (including the derived indices 0, 1 and 2) change neither stored register.
- R4: Pointer bits at and above position 13+S+P come from the descriptor register. Here S is the size code in descriptor bits 3:0, P is the split flag in descriptor bit 12, and descriptor bits 12:0 are never used as base address bits.
- R5: Below that position the pointer takes the fault address, with the fault tag's bits 12:0 treated as zero. The address is shifted right by 9 for the 8 KB pointer (read index 1) and by 12 for the 64 KB pointer (read index 2).
- R6: When the split flag is set, pointer bit 13+S is 0 in the 8 KB pointer and 1 in the 64 KB pointer, whatever the address holds there.
- R7: Bits 3:0 of both pointers always read as zero.
- R8: Reading index 0 returns the tag target. Its bits 60:48 hold fault tag bits 12:0, its bits 41:0 hold fault tag bits 63:22, and every other bit is zero.
- R9: Reads of indices 3, 4 and 7 through 15 return zero.
- R10: Every size code from 0 to 15 is honoured, with and without the split flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register write port |
| wr_idx | input | 4 | Register index of the write |
| wr_data | input | 64 | Write data |
| rd_idx | input | 4 | Register index of the read |
| rd_data | output | 64 | Read data, combinational from rd_idx and the stored registers |

## Verification
The assertions assume that rd_idx, wr_en and wr_idx are always known values, and that the descriptor size code is in 0 to 15. The 4-bit field makes the size range true by construction. The bench meets the first assumption by driving every input from reset onwards and changing them only just after the falling edge. Both stored registers are loaded with patterns that fill all 64 bits. This gives the split and size properties address bits to contradict in both directions. Sweeps over every size code, with the split flag both set and clear, are interleaved with writes to the read-only and unused indices.

// File: rtl/tsbp_pkg.sv
// Shared constants for the translation buffer pointer unit.
// Assumes a 64-bit register file addressed by a 4-bit index.
package tsbp_pkg;
    localparam int DATA_W   = 64;
    localparam int IDX_W    = 4;
    localparam int CTX_W    = 13;   // context field width in the fault tag
    localparam int SIZE_W   = 4;    // size code width in the descriptor
    localparam int SPLIT_B  = 12;   // split flag position in the descriptor
    localparam int LOW_ZERO = 4;    // pointer bits forced to zero
    localparam int TGT_CTX_LSB = 48; // tag-target position of the context
    localparam int TGT_VA_SHIFT = 22; // right shift of the address in the tag target
    localparam int NUM_PTR  = 2;

    // Register index map
    localparam logic [IDX_W-1:0] IDX_TGT   = 4'd0;
    localparam logic [IDX_W-1:0] IDX_PTR8  = 4'd1;
    localparam logic [IDX_W-1:0] IDX_PTR64 = 4'd2;
    localparam logic [IDX_W-1:0] IDX_DESC  = 4'd5;
    localparam logic [IDX_W-1:0] IDX_FTAG  = 4'd6;

    // Pointer variants: right shift of the address and value forced on the split bit
    function automatic int ptr_shift(input int k);
        return (k == 0) ? 9 : 12;
    endfunction

    function automatic logic ptr_split_val(input int k);
        return (k == 0) ? 1'b0 : 1'b1;
    endfunction
endpackage

// File: rtl/tsbp_regs.sv
// Storage for the descriptor and fault tag registers.
// Assumes writes to any index other than the two storage indices are dropped.
module tsbp_regs
    import tsbp_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  desc_q,
    output logic [W-1:0]  ftag_q
);
    localparam int NREG = 2;
    localparam logic [IW-1:0] REG_IDX [NREG] = '{IW'(IDX_DESC), IW'(IDX_FTAG)};

    logic [W-1:0] store [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            // Load one storage register when its own index is written
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    store[g] <= '0;
                end else if (wr_en && wr_idx == REG_IDX[g]) begin
                    store[g] <= wr_data;
                end
            end

            a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == REG_IDX[g]) |=> store[g] == $past(wr_data));
            a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_idx == REG_IDX[g]) |=> $stable(store[g]));
        end
    endgenerate

    assign desc_q = store[0];
    assign ftag_q = store[1];

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (desc_q == '0 && ftag_q == '0));
endmodule

// File: rtl/tsbp_ptr_calc.sv
// Derives one buffer entry pointer from the descriptor and the fault tag.
// Assumes VA_SHIFT is set for the page size and SPLIT_VAL picks the split half.
module tsbp_ptr_calc
    import tsbp_pkg::*;
#(
    parameter int   W         = DATA_W,
    parameter int   VA_SHIFT  = 9,
    parameter logic SPLIT_VAL = 1'b0
) (
    input  logic [W-1:0] desc,
    input  logic [W-1:0] ftag,
    output logic [W-1:0] ptr
);
    localparam logic [W-1:0] HIGH_ONES = {W{1'b1}} << CTX_W;
    localparam logic [W-1:0] LOW_CLR   = {W{1'b1}} << LOW_ZERO;
    localparam int POS_W = $clog2(W);

    logic [SIZE_W-1:0] size_code;
    logic              split;
    logic [W-1:0]      base;
    logic [W-1:0]      mask_sized;
    logic [W-1:0]      mask;
    logic [W-1:0]      va_shifted;
    logic [W-1:0]      va_adj;
    logic [POS_W-1:0]  split_pos;

    assign size_code = desc[SIZE_W-1:0];
    assign split     = desc[SPLIT_B];
    assign base      = desc & HIGH_ONES;
    assign split_pos = POS_W'(CTX_W) + POS_W'(size_code);

    // Build the base mask for the size code and the split flag
    always_comb begin
        mask_sized = HIGH_ONES << size_code;
        mask       = split ? (mask_sized << 1) : mask_sized;
    end

    // Move the fault address into place and force the split bit
    always_comb begin
        va_shifted = (ftag & HIGH_ONES) >> VA_SHIFT;
        va_adj     = va_shifted;
        if (split) begin
            va_adj[split_pos] = SPLIT_VAL;
        end
    end

    // Merge the base and address parts and clear the low bits
    always_comb begin
        ptr = ((base & mask) | (va_adj & ~mask)) & LOW_CLR;
    end
endmodule

// File: rtl/tsbp_tag_tgt.sv
// Rearranges the fault tag into the tag-target comparison word.
// Assumes a 64-bit register with a 13-bit context field in the low bits.
module tsbp_tag_tgt
    import tsbp_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] ftag,
    output logic [W-1:0] tgt
);
    logic [W-1:0] ctx_part;
    logic [W-1:0] va_part;

    // Place the context high and the upper address bits low
    always_comb begin
        ctx_part = W'(ftag[CTX_W-1:0]) << TGT_CTX_LSB;
        va_part  = ftag >> TGT_VA_SHIFT;
        tgt      = ctx_part | va_part;
    end
endmodule

// File: rtl/tsb_ptr_unit.sv
// Top of the translation buffer pointer unit: storage, two pointer
// generators, the tag-target view and the read multiplexer.
// Assumes reads are combinational and all inputs are known after reset.
module tsb_ptr_unit
    import tsbp_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    localparam int POS_W = $clog2(W);

    logic [W-1:0] desc_q;
    logic [W-1:0] ftag_q;
    logic [W-1:0] tgt;
    logic [W-1:0] ptrs [NUM_PTR];

    tsbp_regs #(.W(W), .IW(IW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .desc_q  (desc_q),
        .ftag_q  (ftag_q)
    );

    generate
        for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
            tsbp_ptr_calc #(
                .W         (W),
                .VA_SHIFT  (ptr_shift(k)),
                .SPLIT_VAL (ptr_split_val(k))
            ) u_ptr (
                .desc (desc_q),
                .ftag (ftag_q),
                .ptr  (ptrs[k])
            );
        end
    endgenerate

    tsbp_tag_tgt #(.W(W)) u_tgt (
        .ftag (ftag_q),
        .tgt  (tgt)
    );

    // Select the read value by index; unmapped indices read zero
    always_comb begin
        case (rd_idx)
            IW'(IDX_TGT):   rd_data = tgt;
            IW'(IDX_PTR8):  rd_data = ptrs[0];
            IW'(IDX_PTR64): rd_data = ptrs[1];
            IW'(IDX_DESC):  rd_data = desc_q;
            IW'(IDX_FTAG):  rd_data = ftag_q;
            default:        rd_data = '0;
        endcase
    end

    logic [POS_W-1:0] chk_split_pos;
    assign chk_split_pos = POS_W'(CTX_W) + POS_W'(desc_q[SIZE_W-1:0]);

    // R6: the two pointers fall in opposite halves when split
    a_r6_split_halves: assert property (@(posedge clk) disable iff (!rst_n)
        desc_q[SPLIT_B] |-> (ptrs[0][chk_split_pos] == 1'b0 && ptrs[1][chk_split_pos] == 1'b1));
    // R4: with size 0 and no split the base bits pass straight through
    a_r4_base_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_q[SIZE_W-1:0] == '0 && !desc_q[SPLIT_B]) |-> ptrs[0][W-1:CTX_W] == desc_q[W-1:CTX_W]);
    // R7: pointer reads never carry low bits
    a_r7_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IW'(IDX_PTR8) || rd_idx == IW'(IDX_PTR64)) |-> rd_data[LOW_ZERO-1:0] == '0);
    // R8: the tag target leaves its unused bit ranges empty
    a_r8_tgt_gaps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IW'(IDX_TGT)) |-> (rd_data[W-1:61] == '0 && rd_data[47:42] == '0));
    // R9: unmapped indices read zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == 4'd3 || rd_idx == 4'd4 || rd_idx >= 4'd7) |-> rd_data == '0);
endmodule

// File: tb/tsb_ptr_unit_tb.sv
`timescale 1ns/1ps
module tsb_ptr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [63:0] rd_data;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 0;

    // Behavioural reference state
    logic [63:0] m_desc = '0;
    logic [63:0] m_ftag = '0;

    always #2 clk = ~clk;   // 250 MHz

    tsb_ptr_unit u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // Reference pointer, built bit by bit from R4..R7
    function automatic logic [63:0] ref_ptr(input logic [63:0] d, input logic [63:0] t, input bit big);
        logic [63:0] r = '0;
        int sz = int'(d[3:0]);
        int sp = int'(d[12]);
        int sh = big ? 12 : 9;
        int lim = 13 + sz + sp;
        for (int b = 4; b < 64; b++) begin
            if (b >= lim) r[b] = d[b];
            else if (sp == 1 && b == 13 + sz) r[b] = big;
            else if (b + sh < 64 && b + sh >= 13) r[b] = t[b + sh];
            else r[b] = 1'b0;
        end
        return r;
    endfunction

    // Reference tag target per R8
    function automatic logic [63:0] ref_tgt(input logic [63:0] t);
        logic [63:0] r = '0;
        for (int b = 0; b < 13; b++) r[48 + b] = t[b];
        for (int b = 0; b < 42; b++) r[b] = t[b + 22];
        return r;
    endfunction

    function automatic logic [63:0] ref_read(input logic [3:0] i);
        case (i)
            4'd0: return ref_tgt(m_ftag);
            4'd1: return ref_ptr(m_desc, m_ftag, 1'b0);
            4'd2: return ref_ptr(m_desc, m_ftag, 1'b1);
            4'd5: return m_desc;
            4'd6: return m_ftag;
            default: return 64'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] i);
        if (!rst_n) return "R1";
        case (i)
            4'd0: return "R8";
            4'd1, 4'd2: return "R5";
            4'd5, 4'd6: return "R2";
            default: return "R9";
        endcase
    endfunction

    // Reference register update at each rising edge (R1, R2, R3)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_desc <= '0;
            m_ftag <= '0;
        end else if (wr_en && wr_idx == 4'd5) begin
            m_desc <= wr_data;
        end else if (wr_en && wr_idx == 4'd6) begin
            m_ftag <= wr_data;
        end
    end

    // Compare every cycle on the falling edge, plus the watchdog
    always @(negedge clk) begin
        logic [63:0] exp;
        if (!done) begin
            cycles++;
            exp = rst_n ? ref_read(rd_idx) : 64'd0;
            vectors++;
            if (rd_data !== exp) begin
                miscompares++;
                $display("FAIL %s idx=%0d actual=%h expected=%h", req_of(rd_idx), rd_idx, rd_data, exp);
            end
            if (cycles > 100000) begin
                miscompares++;
                $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
                done = 1;
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        end
    end

    task automatic step(input logic we, input logic [3:0] wi, input logic [63:0] wd, input logic [3:0] ri);
        @(negedge clk);
        #1;
        wr_en = we;
        wr_idx = wi;
        wr_data = wd;
        rd_idx = ri;
    endtask

    task automatic read_all();
        for (int i = 0; i < 16; i++) step(1'b0, 4'd0, 64'd0, 4'(i));
    endtask

    logic [63:0] lfsr = 64'hACE1_2468_BDF0_1357;

    function automatic logic [63:0] next_lfsr(input logic [63:0] v);
        return {v[62:0], v[63] ^ v[62] ^ v[60] ^ v[59]};
    endfunction

    initial begin
        // R1: reads under reset and just after
        for (int i = 0; i < 4; i++) step(1'b0, 4'd0, 64'd0, 4'(i));
        step(1'b0, 4'd0, 64'd0, 4'd0);
        rst_n = 1'b1;
        read_all();

        // R2, R8: load the fault tag with a full-width pattern
        step(1'b1, 4'd6, 64'hFEDC_BA98_7654_3210 | 64'h1FFF, 4'd6);
        read_all();

        // R4, R5, R6, R10: sweep every size code with split clear and set
        for (int sp = 0; sp < 2; sp++) begin
            for (int sz = 0; sz < 16; sz++) begin
                step(1'b1, 4'd5, 64'hA5A5_5A5A_C3C3_E000 | 64'(sp << 12) | 64'(sz), 4'd1);
                step(1'b0, 4'd0, 64'd0, 4'd1);
                step(1'b0, 4'd0, 64'd0, 4'd2);
                // R6: flip the address bit at the split position
                step(1'b1, 4'd6, ~m_ftag, 4'd2);
                step(1'b0, 4'd0, 64'd0, 4'd1);
                step(1'b0, 4'd0, 64'd0, 4'd2);
            end
        end

        // R7: descriptor with all low bits set must not leak into pointers
        step(1'b1, 4'd5, 64'hFFFF_FFFF_FFFF_FFF0, 4'd1);
        step(1'b0, 4'd0, 64'd0, 4'd2);
        step(1'b1, 4'd5, 64'hFFFF_FFFF_FFFF_EFFF, 4'd1);
        step(1'b0, 4'd0, 64'd0, 4'd2);

        // R3: writes to read-only and unmapped indices, then read everything
        for (int i = 0; i < 16; i++) begin
            if (i != 5 && i != 6) step(1'b1, 4'(i), 64'hDEAD_BEEF_0BAD_F00D, 4'd5);
        end
        read_all();

        // Mixed traffic
        for (int n = 0; n < 3000; n++) begin
            lfsr = next_lfsr(lfsr);
            step(lfsr[0], lfsr[4:1], {lfsr[31:0], lfsr[63:32]} ^ {60'd0, lfsr[8:5]}, lfsr[12:9]);
        end

        // R1: reset in the middle of traffic clears everything
        step(1'b1, 4'd5, 64'h1234_5678_9ABC_D00F, 4'd5);
        rst_n = 1'b0;
        step(1'b0, 4'd0, 64'd0, 4'd5);
        step(1'b0, 4'd0, 64'd0, 4'd6);
        rst_n = 1'b1;
        read_all();

        step(1'b0, 4'd0, 64'd0, 4'd0);
        @(negedge clk);
        #1;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule